// File: doc/BRIEF.md
# Frame Store Sequencing Engine

This block is the sequencing core of a unit that stores one composited frame, arriving as a stream of 32-bit pixel words, into memory as a raster image. Software programs a base pointer, a line pitch in bytes and the frame geometry through a small 32-bit register port. It then writes a start bit into the control register. The engine takes the stream one word at a time and gives each word the byte address of its column on its line. It hands the words to a simple request port with a valid/ready handshake.

While a frame runs, the engine shows a busy flag and counts completed lines. When the engine goes idle after a frame has ended or been cut short, it raises a level interrupt if software has enabled one. Software can stop a frame at once with an abort bit, and can put the engine to sleep so that no frame starts. The geometry is captured at the start bit, so software may program the next frame while the current one runs.

Top module: `frame_store_engine`

## Requirements
- R1: Register offsets on `regAddr` are 0x00 base pointer, 0x04 pitch, 0x08 geometry (height in bits 31:16, width in bits 15:0), 0x0C control and 0x10 line count. Base, pitch and geometry read back as written. Control reads 0x54 in bits 31:24, 0b01 in bits 23:22, the sleep flag in bit 21, the interrupt enable in bit 2, busy in bit 1 and 0 in bit 0. Any other offset reads 0.
- R2: A control write with bit 0 set starts a frame when the engine is idle and the same word has neither bit 14 nor bit 21 set. Busy is then set from the next cycle and the line count clears to 0. A start written while busy has no effect on the running frame.
- R3: The word in column c of line n goes out with `memData` equal to the pixel word and `memAddr` equal to B + n·P + 4·c. B is the base pointer with bits 1:0 cleared, and P is the pitch with bits 3:0 cleared.
- R4: `pixReady` is high only while busy and `memReady` is high. `memValid` is high only while busy and `pixValid` is high. When idle, every pixel is refused.
- R5: The line count rises by one each time the last word of a line is accepted. The frame ends when the last word of line height−1 is accepted, and busy reads 0 from the next cycle.
- R6: A control write with bit 14 set while busy ends the frame. Busy is 0 in the next cycle, no further memory request is raised, and the line count holds.
- R7: Control bit 21 is the sleep flag. A start in a word with bit 21 set is refused, and writing bit 21 while busy ends the frame like an abort.
- R8: `irq` is high exactly when the interrupt enable is set, the engine is idle, and a frame has ended or been aborted since the last accepted start. Writing control with bit 2 clear drops it.
- R9: A start accepted with width 0 or height 0 ends at once. Busy never rises, the line count is 0, and the frame counts as ended for R8.
- R10: Base, pitch and geometry are captured at the accepted start. Writes to them during a frame change only later frames.
- R11: After reset all registers are 0, busy is 0, `irq` is 0 and `pixReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| pixValid | input | 1 | Pixel word offered |
| pixData | input | 32 | Pixel word |
| pixReady | output | 1 | Pixel word taken |
| memValid | output | 1 | Memory write request |
| memAddr | output | 32 | Byte address of the word |
| memData | output | 32 | Word to store |
| memReady | input | 1 | Memory accepts the request |
| irq | output | 1 | Level interrupt on idle |

## Verification
The hardest case to reach is a start written while a frame is partly stored. For it to be visible, the running frame has to carry on with the column and line it already held. The bench stops a four-word line after two accepted words and rewrites both the base pointer and the start bit. It then checks that the next address continues the old line from the old base.

An abort in the middle of a line is reached the same way. Pixels are fed one at a time, so the abort lands between two known words, and the bench can then confirm that the line count holds and that requests stay silent.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int REG_AW = 5;
  localparam int DIM_W  = 16;

  localparam logic [REG_AW-1:0] OFS_BASE  = 5'h00;
  localparam logic [REG_AW-1:0] OFS_PITCH = 5'h04;
  localparam logic [REG_AW-1:0] OFS_GEOM  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_LINES = 5'h10;

  localparam int BIT_START = 0;
  localparam int BIT_BUSY  = 1;
  localparam int BIT_IRQEN = 2;
  localparam int BIT_STOP  = 14;
  localparam int BIT_SLEEP = 21;

  localparam logic [7:0] ID_TAG  = 8'h54;
  localparam logic [1:0] REV_TAG = 2'b01;

  // control -> datapath strobes
  typedef struct packed {
    logic start;  // load geometry snapshot, clear counters
    logic run;    // frame in progress
  } ctlStrobe_t;
endpackage

// File: rtl/fse_datapath.sv
module fse_datapath
  import fse_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgPitch,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  output logic              pixReady,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memReady,
  output logic [DIM_W-1:0]  lineCount,
  output logic              frameDone
);
  localparam int WORD_SHIFT = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] pitchSnap;
  logic [ADDR_W-1:0] lineAddr;
  logic [DIM_W-1:0]  widthSnap;
  logic [DIM_W-1:0]  heightSnap;
  logic [DIM_W-1:0]  colIdx;
  logic [ADDR_W-1:0] colOfs;
  logic              wordTaken;
  logic              lastCol;
  logic              lastLine;

  assign pixReady  = strobe.run & memReady;
  assign memValid  = strobe.run & pixValid;
  assign memData   = pixData;
  assign wordTaken = strobe.run & pixValid & memReady;
  assign lastCol   = (colIdx == widthSnap - 1'b1);
  assign lastLine  = (lineCount == heightSnap - 1'b1);
  assign frameDone = wordTaken & lastCol & lastLine;
  assign colOfs    = ADDR_W'(colIdx) << WORD_SHIFT;
  assign memAddr   = lineAddr + colOfs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pitchSnap  <= '0;
      lineAddr   <= '0;
      widthSnap  <= '0;
      heightSnap <= '0;
      colIdx     <= '0;
      lineCount  <= '0;
    end else if (strobe.start) begin
      pitchSnap  <= cfgPitch;
      lineAddr   <= cfgBase;
      widthSnap  <= cfgWidth;
      heightSnap <= cfgHeight;
      colIdx     <= '0;
      lineCount  <= '0;
    end else if (wordTaken) begin
      if (lastCol) begin
        colIdx    <= '0;
        lineCount <= lineCount + 1'b1;
        lineAddr  <= lineAddr + pitchSnap;
      end else begin
        colIdx <= colIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fse_ctrl.sv
module fse_ctrl
  import fse_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [DIM_W-1:0]  lineCount,
  input  logic              frameDone,
  output ctlStrobe_t        strobe,
  output logic [ADDR_W-1:0] cfgBase,
  output logic [ADDR_W-1:0] cfgPitch,
  output logic [DIM_W-1:0]  cfgWidth,
  output logic [DIM_W-1:0]  cfgHeight,
  output logic              busy,
  output logic              irq
);
  logic [31:0] baseReg;
  logic [31:0] pitchReg;
  logic [31:0] geomReg;
  logic        irqEnQ;
  logic        sleepQ;
  logic        busyQ;
  logic        endedQ;
  logic        ctrlWr;
  logic        startOk;
  logic        killReq;
  logic        zeroGeom;
  logic [31:0] ctrlView;

  assign ctrlWr   = regWrEn & (regAddr == OFS_CTRL);
  assign startOk  = ctrlWr & regWrData[BIT_START] & ~busyQ
                  & ~regWrData[BIT_STOP] & ~regWrData[BIT_SLEEP];
  assign killReq  = ctrlWr & busyQ & (regWrData[BIT_STOP] | regWrData[BIT_SLEEP]);
  assign zeroGeom = (geomReg[15:0] == '0) | (geomReg[31:16] == '0);

  assign cfgBase   = {baseReg[ADDR_W-1:2], 2'b00};
  assign cfgPitch  = {pitchReg[ADDR_W-1:4], 4'b0000};
  assign cfgWidth  = geomReg[DIM_W-1:0];
  assign cfgHeight = geomReg[16 +: DIM_W];

  assign strobe.start = startOk;
  assign strobe.run   = busyQ;
  assign busy         = busyQ;
  assign irq          = irqEnQ & ~busyQ & endedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg  <= '0;
      pitchReg <= '0;
      geomReg  <= '0;
      irqEnQ   <= 1'b0;
      sleepQ   <= 1'b0;
    end else if (regWrEn) begin
      case (regAddr)
        OFS_BASE:  baseReg  <= regWrData;
        OFS_PITCH: pitchReg <= regWrData;
        OFS_GEOM:  geomReg  <= regWrData;
        OFS_CTRL: begin
          irqEnQ <= regWrData[BIT_IRQEN];
          sleepQ <= regWrData[BIT_SLEEP];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      endedQ <= 1'b0;
    end else if (startOk) begin
      busyQ  <= ~zeroGeom;
      endedQ <= zeroGeom;
    end else if (killReq | frameDone) begin
      busyQ  <= 1'b0;
      endedQ <= 1'b1;
    end
  end

  always_comb begin
    ctrlView            = '0;
    ctrlView[31:24]     = ID_TAG;
    ctrlView[23:22]     = REV_TAG;
    ctrlView[BIT_SLEEP] = sleepQ;
    ctrlView[BIT_IRQEN] = irqEnQ;
    ctrlView[BIT_BUSY]  = busyQ;
  end

  always_comb begin
    case (regAddr)
      OFS_BASE:  regRdData = baseReg;
      OFS_PITCH: regRdData = pitchReg;
      OFS_GEOM:  regRdData = geomReg;
      OFS_CTRL:  regRdData = ctrlView;
      OFS_LINES: regRdData = 32'(lineCount);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/frame_store_engine.sv
module frame_store_engine
  import fse_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              pixValid,
  input  logic [DATA_W-1:0] pixData,
  output logic              pixReady,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  input  logic              memReady,
  output logic              irq
);
  ctlStrobe_t        strobe;
  logic [ADDR_W-1:0] cfgBase;
  logic [ADDR_W-1:0] cfgPitch;
  logic [DIM_W-1:0]  cfgWidth;
  logic [DIM_W-1:0]  cfgHeight;
  logic [DIM_W-1:0]  lineCount;
  logic              frameDone;
  logic              busy;

  fse_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .lineCount(lineCount), .frameDone(frameDone), .strobe(strobe),
    .cfgBase(cfgBase), .cfgPitch(cfgPitch), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .busy(busy), .irq(irq)
  );

  fse_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgBase(cfgBase), .cfgPitch(cfgPitch), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .memValid(memValid), .memAddr(memAddr), .memData(memData), .memReady(memReady),
    .lineCount(lineCount), .frameDone(frameDone)
  );
endmodule

// File: rtl/fse_checker.sv
module fse_checker
  import fse_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic              busy,
  input logic              pixReady,
  input logic              memValid,
  input logic [1:0]        memAddrLow,
  input logic              irq,
  input logic [DIM_W-1:0]  lineCount
);
  logic stopWr;
  logic sleepWr;
  assign stopWr  = regWrEn & (regAddr == OFS_CTRL) & regWrData[BIT_STOP];
  assign sleepWr = regWrEn & (regAddr == OFS_CTRL) & regWrData[BIT_SLEEP];

  a_r4_idle_refuse: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!pixReady && !memValid));

  a_r8_irq_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busy);

  a_r6_abort_silences: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> (!busy && !memValid));

  a_r7_sleep_keeps_idle: assert property (@(posedge clk) disable iff (!rstN)
    sleepWr |=> !busy);

  a_r5_count_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (lineCount >= $past(lineCount)));

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddrLow == 2'b00));
endmodule

bind frame_store_engine fse_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .busy(busy), .pixReady(pixReady), .memValid(memValid), .memAddrLow(memAddr[1:0]),
  .irq(irq), .lineCount(lineCount)
);

// File: tb/sim_frame_store_engine.sv
`timescale 1ns/1ps
module sim_frame_store_engine;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pixValid = 1'b0;
  logic [31:0] pixData = '0;
  logic        pixReady;
  logic        memValid;
  logic [31:0] memAddr;
  logic [31:0] memData;
  logic        memReady = 1'b1;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(HALF) clk = ~clk;

  frame_store_engine u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .memValid(memValid), .memAddr(memAddr), .memData(memData), .memReady(memReady), .irq(irq)
  );

  // frames: base, pitch, width, height
  localparam logic [31:0] FRAMES [0:2][0:3] = '{
    '{32'h0000_1000, 32'h0000_0040, 32'd3, 32'd2},
    '{32'h0000_2003, 32'h0000_0025, 32'd2, 32'd3},
    '{32'h8000_0000, 32'h0000_0100, 32'd1, 32'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic sendPix(input string tag, input logic [31:0] expAddr, input logic [31:0] d);
    @(negedge clk);
    pixValid = 1'b1; pixData = d;
    #1;
    chk({tag, " R4 ready"}, 32'(pixReady), 32'd1);
    chk({tag, " R3 addr"}, memAddr, expAddr);
    chk({tag, " R3 data"}, memData, d);
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 / R1 reset state
    rd(5'h0C, v); chk("R11 ctrl reset", v, 32'h5440_0000);
    rd(5'h00, v); chk("R11 base reset", v, 32'h0);
    rd(5'h10, v); chk("R11 lines reset", v, 32'h0);
    chk("R11 irq reset", 32'(irq), 32'd0);
    chk("R11 ready reset", 32'(pixReady), 32'd0);
    rd(5'h14, v); chk("R1 unmapped", v, 32'h0);

    // R4 idle refuse
    @(negedge clk); pixValid = 1'b1; #1;
    chk("R4 idle ready", 32'(pixReady), 32'd0);
    chk("R4 idle memValid", 32'(memValid), 32'd0);
    pixValid = 1'b0;

    // table of frames
    for (int f = 0; f < 3; f++) begin
      logic [31:0] b, p;
      b = FRAMES[f][0] & ~32'h3;
      p = FRAMES[f][1] & ~32'hF;
      wr(5'h00, FRAMES[f][0]);
      wr(5'h04, FRAMES[f][1]);
      wr(5'h08, {FRAMES[f][3][15:0], FRAMES[f][2][15:0]});
      rd(5'h08, v); chk("R1 geom readback", v, {FRAMES[f][3][15:0], FRAMES[f][2][15:0]});
      wr(5'h0C, 32'h5);
      rd(5'h0C, v); chk("R2 busy after start", v & 32'h2, 32'h2);
      rd(5'h10, v); chk("R2 lines cleared", v, 32'h0);
      for (int ln = 0; ln < int'(FRAMES[f][3]); ln++) begin
        for (int c = 0; c < int'(FRAMES[f][2]); c++) begin
          sendPix("R3 frame", b + 32'(ln) * p + 32'(4 * c), 32'hA000_0000 + 32'(f * 65536 + ln * 256 + c));
        end
        if (ln + 1 < int'(FRAMES[f][3])) begin
          rd(5'h10, v); chk("R5 lines mid", v, 32'(ln + 1));
        end
      end
      rd(5'h0C, v); chk("R5 idle at end", v & 32'h2, 32'h0);
      rd(5'h10, v); chk("R5 lines final", v, FRAMES[f][3]);
      chk("R8 irq at end", 32'(irq), 32'd1);
      wr(5'h0C, 32'h0);
      chk("R8 irq cleared", 32'(irq), 32'd0);
    end

    // restart ignored mid-frame, geometry snapshot
    wr(5'h00, 32'h0000_4000);
    wr(5'h04, 32'h0000_0080);
    wr(5'h08, 32'h0003_0004);
    wr(5'h0C, 32'h5);
    sendPix("R3 A0", 32'h4000, 32'h11);
    sendPix("R3 A1", 32'h4004, 32'h12);
    wr(5'h00, 32'h0000_9000);
    wr(5'h0C, 32'h5);
    rd(5'h00, v); chk("R1 base readback", v, 32'h0000_9000);
    rd(5'h10, v); chk("R2 restart ignored lines", v, 32'h0);
    sendPix("R10 snapshot", 32'h4008, 32'h13);
    // backpressure
    @(negedge clk); memReady = 1'b0; pixValid = 1'b1; pixData = 32'h14; #1;
    chk("R4 backpressure ready", 32'(pixReady), 32'd0);
    chk("R4 backpressure valid", 32'(memValid), 32'd1);
    @(negedge clk); pixValid = 1'b0; memReady = 1'b1;
    sendPix("R2 continues", 32'h400C, 32'h14);
    rd(5'h10, v); chk("R5 line one", v, 32'h1);
    sendPix("R3 line1", 32'h4080, 32'h15);
    // abort
    wr(5'h0C, 32'h0000_4004);
    rd(5'h0C, v); chk("R6 busy after abort", v & 32'h2, 32'h0);
    @(negedge clk); pixValid = 1'b1; #1;
    chk("R6 no request", 32'(memValid), 32'd0);
    pixValid = 1'b0;
    rd(5'h10, v); chk("R6 lines hold", v, 32'h1);
    chk("R8 irq after abort", 32'(irq), 32'd1);

    // new start clears count, sleep while busy
    wr(5'h0C, 32'h1);
    rd(5'h10, v); chk("R2 count cleared", v, 32'h0);
    rd(5'h0C, v); chk("R2 busy", v & 32'h2, 32'h2);
    chk("R8 irq low after start", 32'(irq), 32'd0);
    wr(5'h0C, 32'h0020_0000);
    rd(5'h0C, v); chk("R7 sleep ends frame", v, 32'h5460_0000);
    wr(5'h0C, 32'h0020_0005);
    rd(5'h0C, v); chk("R7 start refused asleep", v, 32'h5460_0004);
    wr(5'h0C, 32'h0);
    chk("R8 irq off", 32'(irq), 32'd0);

    // zero geometry
    wr(5'h08, 32'h0003_0000);
    wr(5'h0C, 32'h5);
    rd(5'h0C, v); chk("R9 never busy", v & 32'h2, 32'h0);
    chk("R9 irq", 32'(irq), 32'd1);
    rd(5'h10, v); chk("R9 lines", v, 32'h0);
    @(negedge clk); pixValid = 1'b1; #1;
    chk("R9 refuse", 32'(pixReady), 32'd0);
    pixValid = 1'b0;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule